// File: doc/BRIEF.md
# Reference Selector with 8 kHz Phase-Frequency Comparator

This block is the digital front end of a data-rate clock synthesizer. One of four candidate reference sources is picked: the transmit clock, the receive clock, an external station clock, or a 4.096 MHz internal clock. The chosen reference is divided to a common 8 kHz comparison tick. The synthesizer's own output, fed back into the block, is divided to 8 kHz as well. The two ticks drive a phase-frequency detector. Its up and down pulses go on to an analog loop filter, which lies outside this block.

Each source arrives as a one-cycle clock-enable strobe sampled in the fast system clock. A rate setting is given as a code in units of 8 kHz. That code is the division ratio once it is clamped into the legal range for its source, so software never has to work out a divisor. A lock flag reports when the phase error has stayed small for a run of comparisons.

Top module: `refsel_pfd`

## Requirements
- R1: `src_sel` picks the reference: 0 = transmit strobe, 1 = receive strobe, 2 = station strobe, 3 = internal strobe. Strobes of the sources that are not selected have no effect on `up`, `dn` or `locked`.
- R2: The reference is divided by a ratio taken from its rate code, counting strobes. Transmit and receive codes are clamped to 4..256. The station code is clamped to 4..1250. The internal source always uses 512.
- R3: The feedback strobe is divided by `fb_code`, clamped to 4..1250.
- R4: When the reference tick leads the feedback tick by d system cycles, `up` is high for exactly d cycles in each comparison and `dn` stays low.
- R5: When the feedback tick leads by d cycles, `dn` is high for exactly d cycles in each comparison and `up` stays low.
- R6: Ticks that coincide produce neither `up` nor `dn`.
- R7: `up` and `dn` are never high together, and both clear once both ticks of a comparison have arrived.
- R8: `locked` rises on the 16th consecutive comparison whose pulse width is at most `lock_win` cycles, and not before.
- R9: `locked` falls on the first comparison whose pulse width exceeds `lock_win`.
- R10: A change to `src_sel` or to any rate code restarts both dividers. It also clears `up`, `dn` and `locked` at the next clock edge.
- R11: While reset is asserted and just after it, `up`, `dn` and `locked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Reference source choice |
| tx_stb | input | 1 | Transmit clock strobe |
| rx_stb | input | 1 | Receive clock strobe |
| stn_stb | input | 1 | Station clock strobe |
| int_stb | input | 1 | Internal 4.096 MHz strobe |
| fb_stb | input | 1 | Synthesizer feedback strobe |
| tx_code | input | 12 | Transmit rate in 8 kHz units |
| rx_code | input | 12 | Receive rate in 8 kHz units |
| stn_code | input | 12 | Station rate in 8 kHz units |
| fb_code | input | 12 | Feedback ratio to 8 kHz |
| lock_win | input | 8 | Largest pulse width counted as in lock |
| up | output | 1 | Reference-leads pulse |
| dn | output | 1 | Feedback-leads pulse |
| locked | output | 1 | Lock indicator |

## Verification
Two events can fall in the same cycle. One is a comparison closing, because both ticks have now been seen. The other is a new tick from either side. The bench provokes this by starting the reference and feedback strobes in the same cycle, so both divided ticks coincide for the whole run. It judges the result by requiring that neither pulse ever appears while lock is still reached. Comparisons with offsets of one cycle and with offsets equal to the lock window test the boundary where a closing comparison and the window test meet.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SRC_TX  = 2'd0,
    SRC_RX  = 2'd1,
    SRC_STN = 2'd2,
    SRC_INT = 2'd3
  } src_e;
endpackage

// File: rtl/rs_divider.sv
module rs_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         stb,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         tick_q, tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (stb) begin
      if (cnt_q >= div - W'(1)) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R2 / R3: a tick only follows a strobe that was not a restart cycle
  p_tick_from_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> ($past(stb) && !$past(restart)));
endmodule

// File: rtl/rs_pfd.sv
module rs_pfd #(
  parameter int LOCK_N = 16,
  parameter int WIN_W  = 8,
  parameter int ERR_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             ref_tick,
  input  logic             fb_tick,
  input  logic [WIN_W-1:0] win,
  output logic             up,
  output logic             dn,
  output logic             locked
);
  localparam int GW = $clog2(LOCK_N + 1);

  logic             up_q, up_d, dn_q, dn_d, lk_q, lk_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic [GW-1:0]    good_q, good_d;
  logic             up_set, dn_set, done, inwin;
  logic [ERR_W:0]   width;

  always_comb begin
    up_set = up_q | ref_tick;
    dn_set = dn_q | fb_tick;
    done   = up_set & dn_set;
    width  = (up_q | dn_q) ? ({1'b0, err_q} + (ERR_W+1)'(1)) : '0;
    inwin  = width <= (ERR_W+1)'(win);
    up_d   = up_q;
    dn_d   = dn_q;
    err_d  = err_q;
    good_d = good_q;
    lk_d   = lk_q;
    if (restart) begin
      up_d   = 1'b0;
      dn_d   = 1'b0;
      err_d  = '0;
      good_d = '0;
      lk_d   = 1'b0;
    end else if (done) begin
      up_d  = 1'b0;
      dn_d  = 1'b0;
      err_d = '0;
      if (inwin) begin
        if (good_q != GW'(LOCK_N)) good_d = good_q + GW'(1);
        lk_d = (good_d == GW'(LOCK_N));
      end else begin
        good_d = '0;
        lk_d   = 1'b0;
      end
    end else begin
      up_d = up_set;
      dn_d = dn_set;
      if ((up_q | dn_q) && (err_q != {ERR_W{1'b1}})) err_d = err_q + ERR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      err_q  <= '0;
      good_q <= '0;
      lk_q   <= 1'b0;
    end else begin
      up_q   <= up_d;
      dn_q   <= dn_d;
      err_q  <= err_d;
      good_q <= good_d;
      lk_q   <= lk_d;
    end
  end

  assign up     = up_q;
  assign dn     = dn_q;
  assign locked = lk_q;

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));
  p_restart_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!up_q && !dn_q && !lk_q));
  p_up_from_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(ref_tick));
  p_dn_from_fb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_q) |-> $past(fb_tick));
  p_lock_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lk_q) |-> $past(restart || (done && !inwin)));
endmodule

// File: rtl/refsel_pfd.sv
module refsel_pfd #(
  parameter int CODE_W  = 12,
  parameter int DIV_MIN = 4,
  parameter int TRX_MAX = 256,
  parameter int STN_MAX = 1250,
  parameter int INT_DIV = 512,
  parameter int LOCK_N  = 16,
  parameter int WIN_W   = 8,
  parameter int ERR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic              tx_stb,
  input  logic              rx_stb,
  input  logic              stn_stb,
  input  logic              int_stb,
  input  logic              fb_stb,
  input  logic [CODE_W-1:0] tx_code,
  input  logic [CODE_W-1:0] rx_code,
  input  logic [CODE_W-1:0] stn_code,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [WIN_W-1:0]  lock_win,
  output logic              up,
  output logic              dn,
  output logic              locked
);
  import rs_pkg::*;

  localparam int CFG_W = 2 + 4 * CODE_W;

  function automatic logic [CODE_W-1:0] clampc(input logic [CODE_W-1:0] c, input int hi);
    if (int'(c) < DIV_MIN) return CODE_W'(DIV_MIN);
    if (int'(c) > hi)      return CODE_W'(hi);
    return c;
  endfunction

  logic              ref_stb;
  logic [CODE_W-1:0] ref_div, fb_div;
  logic [CFG_W-1:0]  cfg_now, cfg_q, cfg_d;
  logic              restart, ref_tick, fb_tick;

  always_comb begin
    case (src_e'(src_sel))
      SRC_TX:  begin ref_stb = tx_stb;  ref_div = clampc(tx_code, TRX_MAX);  end
      SRC_RX:  begin ref_stb = rx_stb;  ref_div = clampc(rx_code, TRX_MAX);  end
      SRC_STN: begin ref_stb = stn_stb; ref_div = clampc(stn_code, STN_MAX); end
      default: begin ref_stb = int_stb; ref_div = CODE_W'(INT_DIV);          end
    endcase
    fb_div  = clampc(fb_code, STN_MAX);
    cfg_now = {src_sel, tx_code, rx_code, stn_code, fb_code};
    restart = (cfg_now != cfg_q);
    cfg_d   = restart ? cfg_now : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  rs_divider #(.W(CODE_W)) u_ref_div (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .stb(ref_stb), .div(ref_div), .tick(ref_tick)
  );

  rs_divider #(.W(CODE_W)) u_fb_div (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .stb(fb_stb), .div(fb_div), .tick(fb_tick)
  );

  rs_pfd #(.LOCK_N(LOCK_N), .WIN_W(WIN_W), .ERR_W(ERR_W)) u_pfd (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .ref_tick(ref_tick), .fb_tick(fb_tick), .win(lock_win),
    .up(up), .dn(dn), .locked(locked)
  );
endmodule

// File: tb/refsel_pfd_test.sv
module refsel_pfd_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  src_sel;
  logic        tx_stb, rx_stb, stn_stb, int_stb, fb_stb;
  logic [11:0] tx_code, rx_code, stn_code, fb_code;
  logic [7:0]  lock_win;
  logic        up, dn, locked;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  refsel_pfd uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .tx_stb(tx_stb), .rx_stb(rx_stb), .stn_stb(stn_stb), .int_stb(int_stb),
    .fb_stb(fb_stb), .tx_code(tx_code), .rx_code(rx_code), .stn_code(stn_code),
    .fb_code(fb_code), .lock_win(lock_win), .up(up), .dn(dn), .locked(locked)
  );

  // {src 2, code 12, fb 12, fb_leads 1, d 4, win 8, exp_lock 1} = 40 bits
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 12'd4,    12'd4,    1'b0, 4'd0, 8'd3, 1'b1},  // R6 coincident
    {2'd0, 12'd16,   12'd16,   1'b0, 4'd3, 8'd3, 1'b1},  // R4 width = window
    {2'd1, 12'd40,   12'd40,   1'b1, 4'd5, 8'd4, 1'b0},  // R5 outside window
    {2'd2, 12'd100,  12'd100,  1'b0, 4'd2, 8'd2, 1'b1},  // R2 station
    {2'd2, 12'd2000, 12'd1250, 1'b0, 4'd0, 8'd1, 1'b1},  // R2 station clamp high
    {2'd0, 12'd1,    12'd4,    1'b1, 4'd1, 8'd1, 1'b1},  // R2 clamp low
    {2'd1, 12'd300,  12'd256,  1'b0, 4'd7, 8'd8, 1'b1},  // R2 trx clamp high
    {2'd3, 12'd9,    12'd512,  1'b0, 4'd4, 8'd4, 1'b1}   // R2 internal 512
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  function automatic int clampb(input int c, input int hi);
    if (c < 4) return 4;
    if (c > hi) return hi;
    return c;
  endfunction

  task automatic all_ref(input logic v);
    tx_stb = v; rx_stb = v; stn_stb = v; int_stb = v;
  endtask

  task automatic setup(input logic [1:0] s, input int code, input int fb,
                       input bit fb_leads, input int d, input int win);
    all_ref(1'b0); fb_stb = 1'b0;
    @(negedge clk);
    fb_code = 12'd0; tx_code = 12'd4; rx_code = 12'd4; stn_code = 12'd4;
    @(negedge clk);
    src_sel = s; lock_win = 8'(win); fb_code = 12'(fb);
    if (s == 2'd0) tx_code = 12'(code);
    if (s == 2'd1) rx_code = 12'(code);
    if (s == 2'd2) stn_code = 12'(code);
    repeat (2) @(negedge clk);
    if (fb_leads) fb_stb = 1'b1; else all_ref(1'b1);
    repeat (d) @(negedge clk);
    fb_stb = 1'b1; all_ref(1'b1);
  endtask

  task automatic run_vec(input logic [39:0] v, input int idx);
    logic [1:0] s;
    int code, fb, d, win, p, ups, dns;
    bit fbl, expl;
    s = v[39:38]; code = int'(v[37:26]); fb = int'(v[25:14]);
    fbl = v[13]; d = int'(v[12:9]); win = int'(v[8:1]); expl = v[0];
    if (s == 2'd3) p = 512;
    else if (s == 2'd2) p = clampb(code, 1250);
    else p = clampb(code, 256);
    setup(s, code, fb, fbl, d, win);
    repeat (14 * p) @(negedge clk);
    chk(locked == 1'b0, $sformatf("R8 early lock vec%0d", idx), int'(locked), 0);
    repeat (8 * p) @(negedge clk);
    chk(locked == expl, $sformatf("R8 lock vec%0d", idx), int'(locked), int'(expl));
    ups = 0; dns = 0;
    for (int i = 0; i < 4 * p; i++) begin
      @(negedge clk);
      if (up) ups++;
      if (dn) dns++;
    end
    chk(ups == (fbl ? 0 : 4 * d), $sformatf("R4 up width R2 period vec%0d", idx), ups, fbl ? 0 : 4 * d);
    chk(dns == (fbl ? 4 * d : 0), $sformatf("R5 dn width R3 period vec%0d", idx), dns, fbl ? 4 * d : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ups;
    rst_n = 1'b0; src_sel = 2'd0; all_ref(1'b0); fb_stb = 1'b0;
    tx_code = 12'd4; rx_code = 12'd4; stn_code = 12'd4; fb_code = 12'd4; lock_win = 8'd2;
    repeat (3) @(negedge clk);
    chk(!up && !dn && !locked, "R11 reset outputs", int'({up, dn, locked}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!up && !dn && !locked, "R11 after release", int'({up, dn, locked}), 0);

    for (int k = 0; k < NV; k++) run_vec(VEC[k], k);

    // R10: restart clears lock and pulses on the next edge
    run_vec({2'd2, 12'd100, 12'd100, 1'b0, 4'd0, 8'd2, 1'b1}, 90);
    stn_code = 12'd101;
    @(negedge clk);
    chk(!locked && !up && !dn, "R10 restart clears", int'({up, dn, locked}), 0);

    // R1: selected receive strobe silent, all others active
    setup(2'd1, 16, 16, 1'b1, 0, 3);
    rx_stb = 1'b0;
    ups = 0;
    for (int i = 0; i < 20 * 16; i++) begin
      @(negedge clk);
      if (up) ups++;
    end
    chk(ups == 0, "R1 unselected strobes ignored (up)", ups, 0);
    chk(locked == 1'b0, "R1 unselected strobes ignored (locked)", int'(locked), 0);
    chk(dn == 1'b1, "R1 feedback alone holds dn", int'(dn), 1);

    // R9: one late feedback comparison drops lock
    setup(2'd0, 16, 16, 1'b0, 0, 2);
    repeat (22 * 16) @(negedge clk);
    chk(locked == 1'b1, "R9 locked before glitch", int'(locked), 1);
    fb_stb = 1'b0;
    repeat (3) @(negedge clk);
    fb_stb = 1'b1;
    repeat (2 * 16) @(negedge clk);
    chk(locked == 1'b0, "R9 lock dropped", int'(locked), 0);

    finish_run();
  end
endmodule